// File: doc/BRIEF.md
# Transient Vector Instruction Prefix Tracker

This block holds a short prefix that a dedicated prefix instruction attaches to the vector instruction that issues right after it. The prefix instruction writes 10 bits into a field of the vector type register. The next vector instruction reads those bits as extra encoding. When that vector instruction completes, the bits are cleared again. The block does not decode what the prefix means.

The block watches the in-order issue stream. Each event carries a PC, an instruction class, a prefix-support flag and, for prefix instructions, the 15 source bits. It also receives a completion strobe and an interrupt strobe from the vector unit. The block handles misuse by raising an exception and clearing the prefix:

- an illegal source pattern;
- an orphaned prefix;
- a follower that does not accept a prefix.

If an interrupt hits a prefixed instruction, the block redirects the exception PC back to the prefix instruction and loads a resume vstart. Software can then replay the pair. This is what allows the prefix to be virtualized.

Top module: `pfx_tracker`

## Requirements
- R1: A prefix instruction (class 2) with source bits [14:10] all zero, issued while nothing is pending, loads source bits [9:0] into `pfx_bits` and into `type_word` bits [30:21]. Both are visible after the next clock edge, and `exc_code` stays 0. An all-zero payload also arms the block.
- R2: If a vector instruction (class 1) with `iss_pfx_ok` high follows an armed prefix, no exception is raised and `pfx_bits` keeps its value while that instruction executes.
- R3: A `done_i` strobe while the prefixed vector instruction executes clears `pfx_bits` on the next edge without an exception.
- R4: A prefix instruction never changes `vstart_o`.
- R5: A prefix instruction with any of source bits [14:10] set raises `exc_code` 1 with `exc_pc` equal to its own PC. It leaves `pfx_bits` at 0.
- R6: If an armed prefix is followed by a scalar instruction (class 0 or 3) or by another prefix instruction, the block raises `exc_code` 2 with `exc_pc` equal to the armed prefix's PC and clears `pfx_bits`.
- R7: If an armed prefix is followed by a vector instruction with `iss_pfx_ok` low, the block raises `exc_code` 3 with `exc_pc` equal to that vector instruction's PC and clears `pfx_bits`.
- R8: An `irq_i` strobe while the prefixed vector instruction executes raises `exc_code` 4, sets `exc_pc` to the prefix instruction's PC, loads `vstart_o` from `irq_vstart` and clears `pfx_bits`.
- R9: An `irq_i` strobe while a prefix is armed but no follower has issued raises `exc_code` 4 with `exc_pc` equal to the prefix's PC. It clears `pfx_bits` and leaves `vstart_o` unchanged.
- R10: With nothing armed or executing, vector and scalar issues, `done_i` and `irq_i` have no effect: `exc_code` stays 0, `pfx_bits` stays 0 and `vstart_o` is unchanged.
- R11: After reset, `pfx_bits`, `type_word`, `exc_code` and `vstart_o` are all 0. `exc_code` is a one-cycle pulse, and `exc_pc` is meaningful only while `exc_code` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue event this cycle |
| iss_pc | input | 32 | PC of the issuing instruction |
| iss_cls | input | 2 | Class: 0 scalar, 1 vector, 2 prefix, 3 scalar |
| iss_pfx_ok | input | 1 | Vector instruction accepts a prefix |
| iss_src | input | 15 | Source bits of a prefix instruction |
| done_i | input | 1 | Prefixed vector instruction completed |
| irq_i | input | 1 | Interrupt taken this cycle |
| irq_vstart | input | 16 | Resume element index at interrupt |
| pfx_bits | output | 10 | Current prefix |
| type_word | output | 32 | Type register view with the prefix at [30:21] |
| exc_code | output | 3 | 0 none, 1 bad bits, 2 orphan, 3 unsupported, 4 interrupt redirect |
| exc_pc | output | 32 | Exception PC |
| vstart_o | output | 16 | vstart value |

## Verification
Every output is registered. The result of an event sampled at one rising edge is therefore due right after that edge, and an exception code lasts exactly that one cycle. The driver applies each event on a falling edge and pushes the expected prefix, code, PC and vstart for the following rising edge. The monitor pops that item 1 ns after that edge, so each comparison lands in the one cycle where the result is defined. Resume vstart values and prefix PCs are tracked by hand in the driver calls, so the interrupt and orphan paths are checked against values taken from the requirements.

// File: rtl/pfx_tracker.sv
module pfx_tracker #(
  parameter int PCW     = 32,
  parameter int VSW     = 16,
  parameter int PFXW    = 10,
  parameter int SRCW    = 15,
  parameter int TYPEW   = 32,
  parameter int PFX_LSB = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [PCW-1:0]   iss_pc,
  input  logic [1:0]       iss_cls,
  input  logic             iss_pfx_ok,
  input  logic [SRCW-1:0]  iss_src,
  input  logic             done_i,
  input  logic             irq_i,
  input  logic [VSW-1:0]   irq_vstart,
  output logic [PFXW-1:0]  pfx_bits,
  output logic [TYPEW-1:0] type_word,
  output logic [2:0]       exc_code,
  output logic [PCW-1:0]   exc_pc,
  output logic [VSW-1:0]   vstart_o
);
  localparam logic [1:0] CLS_VEC = 2'd1;
  localparam logic [1:0] CLS_PFX = 2'd2;
  localparam logic [2:0] EX_BITS = 3'd1;
  localparam logic [2:0] EX_ORPH = 3'd2;
  localparam logic [2:0] EX_NOPF = 3'd3;
  localparam logic [2:0] EX_IRQ  = 3'd4;

  logic           pend, active;
  logic [PCW-1:0] ppc;
  logic           src_bad;

  assign src_bad   = |iss_src[SRCW-1:PFXW];
  assign type_word = {{(TYPEW-PFXW){1'b0}}, pfx_bits} << PFX_LSB;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      active   <= 1'b0;
      ppc      <= '0;
      pfx_bits <= '0;
      exc_code <= '0;
      exc_pc   <= '0;
      vstart_o <= '0;
    end else begin
      exc_code <= '0;
      if (active) begin
        if (irq_i) begin
          exc_code <= EX_IRQ;
          exc_pc   <= ppc;
          vstart_o <= irq_vstart;
          active   <= 1'b0;
          pfx_bits <= '0;
        end else if (done_i) begin
          active   <= 1'b0;
          pfx_bits <= '0;
        end
      end else if (pend) begin
        if (irq_i) begin
          exc_code <= EX_IRQ;
          exc_pc   <= ppc;
          pend     <= 1'b0;
          pfx_bits <= '0;
        end else if (iss_valid) begin
          pend <= 1'b0;
          if (iss_cls == CLS_VEC && iss_pfx_ok) begin
            active <= 1'b1;
          end else if (iss_cls == CLS_VEC) begin
            exc_code <= EX_NOPF;
            exc_pc   <= iss_pc;
            pfx_bits <= '0;
          end else begin
            exc_code <= EX_ORPH;
            exc_pc   <= ppc;
            pfx_bits <= '0;
          end
        end
      end else if (iss_valid && iss_cls == CLS_PFX) begin
        if (src_bad) begin
          exc_code <= EX_BITS;
          exc_pc   <= iss_pc;
        end else begin
          pend     <= 1'b1;
          ppc      <= iss_pc;
          pfx_bits <= iss_src[PFXW-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/pfx_tracker_chk.sv
module pfx_tracker_chk #(
  parameter int PCW  = 32,
  parameter int VSW  = 16,
  parameter int PFXW = 10,
  parameter int SRCW = 15
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iss_valid,
  input logic [1:0]      iss_cls,
  input logic [SRCW-1:0] iss_src,
  input logic            done_i,
  input logic            irq_i,
  input logic            pend,
  input logic            active,
  input logic [PCW-1:0]  ppc,
  input logic [PFXW-1:0] pfx_bits,
  input logic [2:0]      exc_code,
  input logic [PCW-1:0]  exc_pc,
  input logic [VSW-1:0]  vstart_o
);
  AST_PFX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cls == 2'd2 && iss_src[SRCW-1:PFXW] == '0 && !pend && !active)
    |=> (pfx_bits == $past(iss_src[PFXW-1:0]) && exc_code == 3'd0)); // R1
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && done_i && !irq_i) |=> (pfx_bits == '0 && exc_code == 3'd0)); // R3
  AST_VSTART_ONLY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vstart_o) |-> (exc_code == 3'd4)); // R4
  AST_BADBITS_NO_PFX: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_code == 3'd1) |-> (pfx_bits == '0)); // R5
  AST_ORPHAN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_code == 3'd2) |-> (pfx_bits == '0)); // R6
  AST_NOPFX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_code == 3'd3) |-> (pfx_bits == '0)); // R7
  AST_IRQ_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    (active && irq_i) |=> (exc_code == 3'd4 && exc_pc == $past(ppc) && pfx_bits == '0)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !active && !(iss_valid && iss_cls == 2'd2)) |=> (exc_code == 3'd0 && pfx_bits == '0)); // R10
endmodule

bind pfx_tracker pfx_tracker_chk #(.PCW(PCW), .VSW(VSW), .PFXW(PFXW), .SRCW(SRCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_cls(iss_cls), .iss_src(iss_src),
  .done_i(done_i), .irq_i(irq_i), .pend(pend), .active(active), .ppc(ppc),
  .pfx_bits(pfx_bits), .exc_code(exc_code), .exc_pc(exc_pc), .vstart_o(vstart_o)
);

// File: tb/pfx_tracker_test.sv
module pfx_tracker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [31:0] iss_pc = '0;
  logic [1:0]  iss_cls = '0;
  logic        iss_pfx_ok = 1'b0;
  logic [14:0] iss_src = '0;
  logic        done_i = 1'b0;
  logic        irq_i = 1'b0;
  logic [15:0] irq_vstart = '0;
  logic [9:0]  pfx_bits;
  logic [31:0] type_word;
  logic [2:0]  exc_code;
  logic [31:0] exc_pc;
  logic [15:0] vstart_o;

  typedef struct {
    logic [2:0]  code;
    logic [31:0] pc;
    logic [9:0]  pfx;
    logic [15:0] vs;
    string       req;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  pfx_tracker uut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_pc(iss_pc), .iss_cls(iss_cls),
    .iss_pfx_ok(iss_pfx_ok), .iss_src(iss_src), .done_i(done_i), .irq_i(irq_i),
    .irq_vstart(irq_vstart), .pfx_bits(pfx_bits), .type_word(type_word),
    .exc_code(exc_code), .exc_pc(exc_pc), .vstart_o(vstart_o)
  );

  task automatic compare(input exp_t e);
    logic [31:0] tw;
    tw = {12'd0, e.pfx, 10'd0} << 11;
    n_vec++;
    if (exc_code !== e.code || pfx_bits !== e.pfx || type_word !== tw || vstart_o !== e.vs ||
        (e.code != 3'd0 && exc_pc !== e.pc)) begin
      n_bad++;
      $display("FAIL %s: code=%0d pfx=%h type=%h pc=%h vs=%h expected code=%0d pfx=%h type=%h pc=%h vs=%h",
               e.req, exc_code, pfx_bits, type_word, exc_pc, vstart_o,
               e.code, e.pfx, tw, e.pc, e.vs);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] pc, input logic [1:0] cls, input bit ok,
                      input logic [14:0] src, input bit dn, input bit irq, input logic [15:0] ivs,
                      input logic [2:0] ecode, input logic [31:0] epc, input logic [9:0] epfx,
                      input logic [15:0] evs, input string req);
    exp_t e;
    @(negedge clk);
    iss_valid = v; iss_pc = pc; iss_cls = cls; iss_pfx_ok = ok; iss_src = src;
    done_i = dn; irq_i = irq; irq_vstart = ivs;
    e.code = ecode; e.pc = epc; e.pfx = epfx; e.vs = evs; e.req = req;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin : watchdog
    #500us;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : driver
    exp_t r;
    repeat (3) @(posedge clk);
    #1;
    r.code = 0; r.pc = 0; r.pfx = 0; r.vs = 0; r.req = "R11 reset";
    compare(r);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 load, R2 accepted follower kept, R3 clear on done
    step(1, 32'h100, 2, 0, 15'h2A5, 0, 0, 0, 0, 0, 10'h2A5, 0, "R1 load");
    step(1, 32'h104, 1, 1, 15'h000, 0, 0, 0, 0, 0, 10'h2A5, 0, "R2 accept");
    step(0, 32'h0,   0, 0, 15'h000, 0, 0, 0, 0, 0, 10'h2A5, 0, "R2 hold");
    step(0, 32'h0,   0, 0, 15'h000, 1, 0, 0, 0, 0, 10'h000, 0, "R3 done");
    // R5 illegal source bits
    step(1, 32'h200, 2, 0, 15'h7C05, 0, 0, 0, 1, 32'h200, 0, 0, "R5 badbits");
    step(1, 32'h204, 2, 0, 15'h0400, 0, 0, 0, 1, 32'h204, 0, 0, "R5 lowest bad bit");
    // R6 orphan after scalar and after another prefix
    step(1, 32'h300, 2, 0, 15'h3FF, 0, 0, 0, 0, 0, 10'h3FF, 0, "R1 all ones");
    step(1, 32'h304, 0, 0, 15'h000, 0, 0, 0, 2, 32'h300, 0, 0, "R6 scalar follower");
    step(1, 32'h400, 2, 0, 15'h001, 0, 0, 0, 0, 0, 10'h001, 0, "R1 load");
    step(1, 32'h404, 2, 0, 15'h002, 0, 0, 0, 2, 32'h400, 0, 0, "R6 prefix follower");
    step(1, 32'h410, 2, 0, 15'h000, 0, 0, 0, 0, 0, 10'h000, 0, "R1 zero payload");
    step(1, 32'h414, 3, 0, 15'h000, 0, 0, 0, 2, 32'h410, 0, 0, "R6 class3 follower");
    // R7 unsupported vector follower
    step(1, 32'h500, 2, 0, 15'h155, 0, 0, 0, 0, 0, 10'h155, 0, "R1 load");
    step(1, 32'h504, 1, 0, 15'h000, 0, 0, 0, 3, 32'h504, 0, 0, "R7 unsupported");
    // R8 interrupt during prefixed instruction
    step(1, 32'h600, 2, 0, 15'h0AA, 0, 0, 0, 0, 0, 10'h0AA, 0, "R1 load");
    step(1, 32'h604, 1, 1, 15'h000, 0, 0, 0, 0, 0, 10'h0AA, 0, "R2 accept");
    step(0, 32'h0,   0, 0, 15'h000, 0, 1, 16'h0037, 4, 32'h600, 0, 16'h0037, "R8 irq rewind");
    step(0, 32'h0,   0, 0, 15'h000, 0, 0, 0, 0, 0, 0, 16'h0037, "R11 pulse ends");
    // R4 prefix keeps vstart, R9 irq while armed
    step(1, 32'h700, 2, 0, 15'h0F0, 0, 0, 0, 0, 0, 10'h0F0, 16'h0037, "R4 vstart kept");
    step(0, 32'h0,   0, 0, 15'h000, 0, 1, 16'h0099, 4, 32'h700, 0, 16'h0037, "R9 irq armed");
    // R10 idle events ignored
    step(1, 32'h800, 1, 1, 15'h000, 0, 0, 0, 0, 0, 0, 16'h0037, "R10 idle vector");
    step(1, 32'h804, 0, 0, 15'h000, 0, 0, 0, 0, 0, 0, 16'h0037, "R10 idle scalar");
    step(0, 32'h0,   0, 0, 15'h000, 1, 0, 0, 0, 0, 0, 16'h0037, "R10 idle done");
    step(0, 32'h0,   0, 0, 15'h000, 0, 1, 16'h0055, 0, 0, 0, 16'h0037, "R10 idle irq");
    // R3 again after a recovered run
    step(1, 32'h900, 2, 0, 15'h201, 0, 0, 0, 0, 0, 10'h201, 16'h0037, "R4 load keeps vstart");
    step(1, 32'h904, 1, 1, 15'h000, 0, 0, 0, 0, 0, 10'h201, 16'h0037, "R2 accept");
    step(0, 32'h0,   0, 0, 15'h000, 1, 0, 0, 0, 0, 0, 16'h0037, "R3 done");
    step(0, 32'h0,   0, 0, 15'h000, 0, 0, 0, 0, 0, 0, 16'h0037, "R10 quiet");
    @(negedge clk);
    iss_valid = 0; done_i = 0; irq_i = 0;
    repeat (3) @(posedge clk);
    #2;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule